// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers every interrupt source of a serial-bus master peripheral into one host interrupt request. It has two kinds of source. A parameterized number of external device pins (`NUM_EXT`, which may be zero) are each synchronized and captured on their rising edge. Two internal events come from the queues next to the block: a push strobe from the response queue, and a watcher on the command queue's fill level. The watcher fires when the fill level comes to equal a programmable threshold.

Every source sets its own sticky pending bit. Software reads the pending bits and clears them by writing ones to the pending register. A mask register chooses which pending bits can drive the output, and that output is registered. The bus decoder lies outside the block. The block offers a simple register write port (enable, 2-bit address, 32-bit data) and a combinational read port.

The threshold watcher is a two-state machine. State `TH_MATCH` means the fill level equals the threshold. State `TH_APART` means it does not. The transition `TH_MATCH -> TH_APART` is taken when the two stop being equal, and it raises no event. The transition `TH_APART -> TH_MATCH` is taken when they become equal, and it raises the threshold event for that one cycle. Staying in either state raises nothing. The watcher resets into `TH_MATCH`.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the pending, mask and threshold registers all read zero and `irq_o` is 0. No event is raised while the fill level stays equal to the reset threshold.
- R2: When `rsp_push_i` is high at a clock edge, pending bit 0 is set after that edge.
- R3: Pending bit 1 is set only in the cycle where the zero-extended `cmd_level_i` becomes equal to the threshold (`TH_APART -> TH_MATCH`). While the two stay equal, a cleared bit 1 stays clear.
- R4: A rising edge on `ext_irq_i[i]` sets pending bit 2+i. The bit is set at the third clock edge after the pin rises. A pin held high sets the bit only once.
- R5: Read addresses: 0 is the threshold, 1 is the pending register, 2 is the mask register. Address 3 and pending or mask bits at index `NUM_EXT+2` and above read as 0.
- R6: A write to address 1 clears every pending bit written as 1 and leaves every bit written as 0 unchanged.
- R7: If a source event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R8: `irq_o` is 1 in the cycle after any bit of (pending AND mask) is 1. Otherwise it is 0.
- R9: A pending bit whose mask bit is 0 does not drive `irq_o`. Mask bit positions are the same as pending bit positions.
- R10: The threshold at address 0 is a full 32-bit read/write register. A threshold above the largest fill level never sets bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_irq_i | input | max(NUM_EXT,1) | External device interrupt pins, asynchronous |
| rsp_push_i | input | 1 | Response queue push strobe |
| cmd_level_i | input | FILL_W | Command queue fill count |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Registered interrupt request to the host |

## Verification
The threshold watcher is driven with three level patterns. The first moves onto the threshold, which separates a transition-qualified event from a level-qualified one. The second holds the level on the threshold after a clear, which shows whether the event fires again. The third moves away and back, which shows whether it re-arms. External pins are held high across a clear, which separates edge capture from level capture, and the check is timed to find off-by-one errors in the synchronizer depth. Further tests apply clears that land together with a push, partial clear masks, and mask patterns that enable and disable single sources. These separate write-one-to-clear from plain overwrite and show the priority of an event over a clear.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register addresses on the simple read/write ports
    typedef enum logic [1:0] {
        REG_THRESH = 2'd0,
        REG_PEND   = 2'd1,
        REG_MASK   = 2'd2
    } reg_addr_e;

    // Fixed bit positions inside the pending and mask registers
    localparam int BIT_RSP  = 0;
    localparam int BIT_THR  = 1;
    localparam int BIT_EXT0 = 2;

    // Threshold watcher states
    typedef enum logic {
        TH_MATCH = 1'b0,
        TH_APART = 1'b1
    } th_state_e;

endpackage

// File: rtl/ext_edge.sv
module ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~last_q;

    // A pin held high yields a single one-cycle pulse
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/thr_watch.sv
module thr_watch
    import irq_agg_pkg::*;
#(
    parameter int FILL_W = 6,
    parameter int THR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] level_i,
    input  logic [THR_W-1:0]  thr_i,
    output logic              evt_o
);
    th_state_e state_q, state_n;
    logic      match;

    assign match = (THR_W'(level_i) == thr_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TH_MATCH;
        else        state_q <= state_n;
    end

    // Next state and event output
    always_comb begin
        state_n = state_q;
        evt_o   = 1'b0;
        unique case (state_q)
            TH_MATCH: if (!match) state_n = TH_APART;
            TH_APART: if (match) begin
                state_n = TH_MATCH;
                evt_o   = 1'b1;
            end
        endcase
    end

    p_event_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> (state_q == TH_MATCH));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_EXT = 2,
    parameter int FILL_W  = 6,
    parameter int THR_W   = 32,
    parameter int DATA_W  = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [((NUM_EXT > 0) ? NUM_EXT : 1)-1:0] ext_irq_i,
    input  logic                                rsp_push_i,
    input  logic [FILL_W-1:0]                   cmd_level_i,
    input  logic                                wr_en_i,
    input  logic [1:0]                          wr_addr_i,
    input  logic [DATA_W-1:0]                   wr_data_i,
    input  logic [1:0]                          rd_addr_i,
    output logic [DATA_W-1:0]                   rd_data_o,
    output logic                                irq_o
);
    localparam int NSRC = NUM_EXT + 2;

    logic [NSRC-1:0]  evt;
    logic [NSRC-1:0]  pend_q, mask_q, clr;
    logic [THR_W-1:0] thr_q;
    logic             thr_evt;
    logic             wr_pend, wr_mask, wr_thr;

    thr_watch #(.FILL_W(FILL_W), .THR_W(THR_W)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (cmd_level_i),
        .thr_i   (thr_q),
        .evt_o   (thr_evt)
    );

    assign evt[BIT_RSP] = rsp_push_i;
    assign evt[BIT_THR] = thr_evt;

    generate
        for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
            ext_edge u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (ext_irq_i[i]),
                .rise_o (evt[BIT_EXT0 + i])
            );
        end
    endgenerate

    assign wr_pend = wr_en_i && (wr_addr_i == REG_PEND);
    assign wr_mask = wr_en_i && (wr_addr_i == REG_MASK);
    assign wr_thr  = wr_en_i && (wr_addr_i == REG_THRESH);
    assign clr     = wr_pend ? wr_data_i[NSRC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
            thr_q  <= '0;
            irq_o  <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr) | evt;
            if (wr_mask) mask_q <= wr_data_i[NSRC-1:0];
            if (wr_thr)  thr_q  <= THR_W'(wr_data_i);
            irq_o  <= |(pend_q & mask_q);
        end
    end

    always_comb begin
        case (rd_addr_i)
            REG_THRESH: rd_data_o = DATA_W'(thr_q);
            REG_PEND:   rd_data_o = DATA_W'(pend_q);
            REG_MASK:   rd_data_o = DATA_W'(mask_q);
            default:    rd_data_o = '0;
        endcase
    end

    // Assertions next to the logic they guard
    logic lvl_match;
    assign lvl_match = (THR_W'(cmd_level_i) == thr_q);

    p_push_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_push_i |=> pend_q[BIT_RSP]);

    p_no_refire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_match && $past(lvl_match)) |-> !thr_evt);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && wr_data_i[BIT_RSP] && !rsp_push_i) |=> !pend_q[BIT_RSP]);

    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && wr_data_i[BIT_THR] && thr_evt) |=> pend_q[BIT_THR]);

    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & mask_q)) |=> irq_o);

    p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq_o);

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
    localparam int NUM_EXT = 2;
    localparam int FILL_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_EXT-1:0] ext_irq = '0;
    logic              rsp_push = 1'b0;
    logic [FILL_W-1:0] level = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [1:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_aggregator #(.NUM_EXT(NUM_EXT), .FILL_W(FILL_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_irq_i   (ext_irq),
        .rsp_push_i  (rsp_push),
        .cmd_level_i (level),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        cyc(3);
        rd(2'd0, d); check("R1 threshold reset", d, 32'h0);
        rd(2'd1, d); check("R1 pending reset, no event at matched reset", d, 32'h0);
        rd(2'd2, d); check("R1 mask reset", d, 32'h0);
        check("R1 irq reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_push_irq();
        logic [31:0] d;
        wr(2'd2, 32'h1);
        @(negedge clk); rsp_push = 1'b1;
        @(negedge clk); rsp_push = 1'b0;
        rd(2'd1, d); check("R2 push sets bit0", d, 32'h1);
        check("R8 irq not yet set same cycle as pending", {31'b0, irq}, 32'h0);
        cyc(1);
        check("R8 irq one cycle after pending", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'h1);
        rd(2'd1, d); check("R6 clear bit0", d, 32'h0);
        cyc(1);
        check("R8 irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_threshold();
        logic [31:0] d;
        level = 6'd10;
        wr(2'd0, 32'd5);
        cyc(1);
        rd(2'd1, d); check("R3 no event while apart", d, 32'h0);
        level = 6'd5;
        cyc(1);
        rd(2'd1, d); check("R3 event on reaching threshold", d, 32'h2);
        wr(2'd1, 32'h2);
        cyc(4);
        rd(2'd1, d); check("R3 no refire while level held", d, 32'h0);
        level = 6'd6; cyc(1);
        level = 6'd5; cyc(1);
        rd(2'd1, d); check("R3 refire after leaving and returning", d, 32'h2);
        wr(2'd1, 32'h2);
        wr(2'd0, 32'hDEAD_BEEF);
        rd(2'd0, d); check("R10 threshold full 32-bit readback", d, 32'hDEAD_BEEF);
        level = 6'd0;  cyc(1);
        level = 6'd63; cyc(1);
        rd(2'd1, d); check("R10 out-of-range threshold never matches", d, 32'h0);
        wr(2'd0, 32'd20);
        level = 6'd10;
        cyc(1);
    endtask

    task automatic t_external();
        logic [31:0] d;
        @(negedge clk); ext_irq[1] = 1'b1;
        cyc(2);
        rd(2'd1, d); check("R4 not set before sync latency", d, 32'h0);
        cyc(1);
        rd(2'd1, d); check("R4 ext1 sets bit3 at third edge", d, 32'h8);
        wr(2'd1, 32'h8);
        cyc(4);
        rd(2'd1, d); check("R4 held level does not re-set", d, 32'h0);
        ext_irq[1] = 1'b0; ext_irq[0] = 1'b1;
        cyc(4);
        rd(2'd1, d); check("R4 ext0 sets bit2", d, 32'h4);
        ext_irq[0] = 1'b0;
        wr(2'd1, 32'hF);
    endtask

    task automatic t_clear_rules();
        logic [31:0] d;
        @(negedge clk); rsp_push = 1'b1;
        @(negedge clk); rsp_push = 1'b0;
        level = 6'd20; cyc(1);
        rd(2'd1, d); check("R6 setup bits0,1", d, 32'h3);
        wr(2'd1, 32'h2);
        rd(2'd1, d); check("R6 zeros leave bits", d, 32'h1);
        @(negedge clk);
        rsp_push = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h1;
        @(negedge clk);
        rsp_push = 1'b0; wr_en = 1'b0;
        rd(2'd1, d); check("R7 event wins over clear", d, 32'h1);
        wr(2'd1, 32'h1);
    endtask

    task automatic t_mask_read();
        logic [31:0] d;
        wr(2'd2, 32'h0000_0002);
        @(negedge clk); rsp_push = 1'b1;
        @(negedge clk); rsp_push = 1'b0;
        cyc(2);
        check("R9 masked bit0 does not raise irq", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, d); check("R5 mask upper bits read zero", d, 32'h0000_000F);
        rd(2'd3, d); check("R5 unused address reads zero", d, 32'h0);
        cyc(1);
        check("R9 enabling mask raises irq", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R5 pending upper bits read zero", d, 32'h0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(2);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_push_irq();
        t_threshold();
        t_external();
        t_clear_rules();
        t_mask_read();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule